// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block gathers a set of asynchronous external request lines into a single interrupt request for a host processor. It also produces a single wakeup event output. Each line passes through a two-stage synchroniser. The line can then be armed to detect a rising transition, a falling transition, or both. A detected transition latches a per-line pending flag, and that flag stays set until software writes a one to it. A per-line interrupt enable decides which pending flags reach the interrupt output. A separate per-line event enable turns detected transitions into a one-cycle wakeup pulse. Software can also raise any pending flag on its own through a software-trigger register.

Software reaches the block through a simple register port: one 32-bit data bus and a three-bit word index. Writes take effect on the clock edge that samples them. Read data is registered and appears one cycle after the request. A parameter sets how many lines actually exist. Storage for the other bit positions is tied to zero. Software can therefore count the lines by writing all ones into the rising-select register and reading it back.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `evt_o` are low.
- R2: Bits at positions `NUM_LINES` and above read zero in every register. Writing all ones to the rising-select register (index 2) reads back as `2**NUM_LINES-1`, which is 0x000FFFFF with the default of 20 lines.
- R3: Suppose a line's rising-select bit is set and the line goes from 0 to 1. That line's pending bit (register index 5, bit = line number) is then set on the third rising clock edge after the input change.
- R4: A line whose falling-select bit (register index 3) is set latches pending on a 1-to-0 transition. A line with both select bits set latches on either transition. A line with neither bit set never latches from its input.
- R5: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R6: A set request that lands in the same cycle as a write-one-to-clear of the same bit wins, so the bit stays set.
- R7: `irq_o` is registered. It equals the OR over all lines of (pending AND interrupt-enable bit, register index 0), as seen one cycle earlier. A pending line whose enable bit is clear has no effect on `irq_o`.
- R8: `evt_o` is high for exactly one cycle when an enabled transition occurs on a line whose event-enable bit (register index 1) is set. The pulse comes in the same cycle the pending bit becomes visible. Lines whose event-enable bit is clear produce no pulse.
- R9: Writing a 1 to a bit of the software-trigger register (index 4) sets that bit and the matching pending bit. The trigger bit reads 1 until the pending bit is cleared, and then reads 0. Writing 0 to a trigger bit has no effect.
- R10: The registers are at word indexes 0 (interrupt enable), 1 (event enable), 2 (rising select), 3 (falling select), 4 (software trigger) and 5 (pending). Indexes 6 and 7 read zero, and writes to them change nothing. Read data is valid one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_i | input | NUM_LINES | Asynchronous external request lines |
| acc_en | input | 1 | Register access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Register word index |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | 1 | One-cycle wakeup event pulse |

## Verification
A pending flag that is stuck, or one set by the wrong polarity, becomes visible on a read of index 5 within four cycles of the stimulus. It also reaches `irq_o` one cycle after the flag itself once that line is enabled. A wrong clear priority only shows when a transition and a clear write fall in the same cycle, so the bench lines them up exactly. A stale software-trigger bit shows on the next read of index 4 after its pending bit is cleared. A bad implemented-line mask shows at once on the rising-select readback.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_IEN  = 3'd0,
    IDX_EEN  = 3'd1,
    IDX_RSEL = 3'd2,
    IDX_FSEL = 3'd3,
    IDX_SWT  = 3'd4,
    IDX_PEND = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/xirq_sync.sv
// Two-flop synchroniser, one chain per implemented line.
module xirq_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/xirq_edge.sv
// Compares each synchronised level with its previous sample and qualifies the
// transition with the per-line polarity selects.
module xirq_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit_o[i] = (level_i[i] & ~prev_q[i] & rise_en_i[i]) |
                 (~level_i[i] & prev_q[i] & fall_en_i[i]);
    end
  end
endmodule

// File: rtl/xirq_regs.sv
// Register file: enables, polarity selects, software trigger and pending flags.
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic [DATA_W-1:0] hit_i,
  output logic [DATA_W-1:0] ien_o,
  output logic [DATA_W-1:0] een_o,
  output logic [DATA_W-1:0] rsel_o,
  output logic [DATA_W-1:0] fsel_o,
  output logic [DATA_W-1:0] swt_o,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] set_o,
  output logic [DATA_W-1:0] clr_o
);
  localparam logic [DATA_W-1:0] IMPL =
    (NUM_LINES >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << NUM_LINES) - DATA_W'(1));

  logic [DATA_W-1:0] ien_q, een_q, rsel_q, fsel_q, swt_q, pend_q, rdata_q;
  logic [DATA_W-1:0] wmask, sw_set, pend_nxt, swt_nxt, rd_mux;
  logic              wr_ok;

  assign wr_ok = acc_en & acc_wr;
  assign wmask = acc_wdata & IMPL;

  always_comb begin
    sw_set = '0;
    clr_o  = '0;
    if (wr_ok && acc_idx == IDX_SWT)  sw_set = wmask;
    if (wr_ok && acc_idx == IDX_PEND) clr_o  = wmask;
  end

  assign set_o    = (hit_i & IMPL) | sw_set;
  assign pend_nxt = (pend_q & ~clr_o) | set_o;
  assign swt_nxt  = (swt_q | sw_set) & pend_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      een_q  <= '0;
      rsel_q <= '0;
      fsel_q <= '0;
      swt_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_nxt;
      swt_q  <= swt_nxt;
      if (wr_ok) begin
        case (acc_idx)
          IDX_IEN:  ien_q  <= wmask;
          IDX_EEN:  een_q  <= wmask;
          IDX_RSEL: rsel_q <= wmask;
          IDX_FSEL: fsel_q <= wmask;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (acc_idx)
      IDX_IEN:  rd_mux = ien_q;
      IDX_EEN:  rd_mux = een_q;
      IDX_RSEL: rd_mux = rsel_q;
      IDX_FSEL: rd_mux = fsel_q;
      IDX_SWT:  rd_mux = swt_q;
      IDX_PEND: rd_mux = pend_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '0;
    else if (acc_en && !acc_wr) rdata_q <= rd_mux;
  end

  assign acc_rdata = rdata_q;
  assign ien_o  = ien_q;
  assign een_o  = een_q;
  assign rsel_o = rsel_q;
  assign fsel_o = fsel_q;
  assign swt_o  = swt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ext_i,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic [DATA_W-1:0]    acc_wdata,
  output logic [DATA_W-1:0]    acc_rdata,
  output logic                 irq_o,
  output logic                 evt_o
);
  logic [NUM_LINES-1:0] sync_lv;
  logic [DATA_W-1:0]    level_w, hit_w;
  logic [DATA_W-1:0]    ien_q, een_q, rsel_q, fsel_q, swt_q, pend_q, set_vec, clr_vec;
  logic                 irq_q, evt_q;

  xirq_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ext_i), .sync_o(sync_lv)
  );

  always_comb begin
    level_w = '0;
    level_w[NUM_LINES-1:0] = sync_lv;
  end

  xirq_edge #(.W(DATA_W)) u_edge (
    .clk(clk), .rst(rst), .level_i(level_w),
    .rise_en_i(rsel_q), .fall_en_i(fsel_q), .hit_o(hit_w)
  );

  xirq_regs #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .hit_i(hit_w),
    .ien_o(ien_q), .een_o(een_q), .rsel_o(rsel_q), .fsel_o(fsel_q),
    .swt_o(swt_q), .pend_o(pend_q), .set_o(set_vec), .clr_o(clr_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      irq_q <= |(pend_q & ien_q);
      evt_q <= |(hit_w & een_q);
    end
  end

  assign irq_o = irq_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic              evt_o,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] ien_q,
  input logic [DATA_W-1:0] rsel_q,
  input logic [DATA_W-1:0] swt_q,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] clr_vec
);
  localparam logic [DATA_W-1:0] IMPL =
    (NUM_LINES >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << NUM_LINES) - DATA_W'(1));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0 && !irq_o && !evt_o));

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | rsel_q | swt_q) & ~IMPL) == '0);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0 && set_vec == '0) |=> ((pend_q & $past(clr_vec)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(pend_q & ien_q))));

  assert_evt_pending_R8: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (pend_q != '0));

  assert_swt_subset_R9: assert property (@(posedge clk) disable iff (rst)
    (swt_q & ~pend_q) == '0);
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .evt_o(evt_o),
  .pend_q(pend_q), .ien_q(ien_q), .rsel_q(rsel_q), .swt_q(swt_q),
  .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NL = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] ext = '0;
  logic          acc_en = 1'b0, acc_wr = 1'b0;
  logic [2:0]    acc_idx = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic          irq_o, evt_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl #(.DATA_W(DW), .NUM_LINES(NL)) dut_i (
    .clk(clk), .rst(rst), .ext_i(ext), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [DW-1:0] d);
    acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
    @(negedge clk);
    d = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(idx, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 6; i++) rd_chk("R1 register zero", 3'(i), '0);
    check("R1 irq low", {31'b0, irq_o}, 0);
    check("R1 evt low", {31'b0, evt_o}, 0);
  endtask

  task automatic t_unimpl;
    wr(3'd2, '1);
    rd_chk("R2 rise readback", 3'd2, 32'h000F_FFFF);
    wr(3'd0, '1);
    rd_chk("R2 ien readback", 3'd0, 32'h000F_FFFF);
    wr(3'd2, '0);
    wr(3'd0, '0);
  endtask

  task automatic t_rise;
    wr(3'd2, 32'h1);
    ext[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_chk("R3 not yet pending", 3'd5, 32'h0); // edge k+2 not reached when sampled
    rd_chk("R3 rising pending", 3'd5, 32'h1);
    wr(3'd5, 32'h1);
    ext[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R3 rise-only ignores fall", 3'd5, 32'h0);
    wr(3'd2, '0);
  endtask

  task automatic t_fall_both;
    wr(3'd3, 32'h8);
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h18);
    ext[3] = 1'b1; ext[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R4 fall-only ignores rise", 3'd5, 32'h0);
    ext[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R4 both rise", 3'd5, 32'h10);
    wr(3'd5, 32'h10);
    ext[3] = 1'b0; ext[4] = 1'b0; ext[5] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R4 falls latched, none-select line 5 ignored", 3'd5, 32'h18);
    wr(3'd5, 32'h18);
    wr(3'd2, '0); wr(3'd3, '0);
  endtask

  task automatic t_w1c;
    wr(3'd4, 32'h6);
    rd_chk("R5 both set", 3'd5, 32'h6);
    wr(3'd5, 32'h2);
    rd_chk("R5 one cleared", 3'd5, 32'h4);
    wr(3'd5, 32'h0);
    rd_chk("R5 zero write no effect", 3'd5, 32'h4);
    wr(3'd5, 32'h4);
  endtask

  task automatic t_priority;
    wr(3'd2, 32'h40);
    ext[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(3'd5, 32'h40);   // lands on the same edge as the set
    rd_chk("R6 set beats clear", 3'd5, 32'h40);
    wr(3'd5, 32'h40);
    rd_chk("R6 later clear works", 3'd5, 32'h0);
    wr(3'd2, '0);
    ext[6] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_irq;
    wr(3'd4, 32'h100);
    repeat (2) @(negedge clk);
    check("R7 masked pending no irq", {31'b0, irq_o}, 0);
    wr(3'd0, 32'h100);
    check("R7 irq not before one cycle", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R7 irq high", {31'b0, irq_o}, 1);
    wr(3'd5, 32'h100);
    @(negedge clk);
    check("R7 irq drops after clear", {31'b0, irq_o}, 0);
    wr(3'd0, '0);
  endtask

  task automatic t_event;
    wr(3'd2, 32'h600);
    wr(3'd1, 32'h200);
    ext[9] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 no pulse early", {31'b0, evt_o}, 0);
    @(negedge clk);
    check("R8 pulse", {31'b0, evt_o}, 1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, evt_o}, 0);
    ext[10] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R8 no pulse on event-disabled line", {31'b0, evt_o}, 0);
    end
    rd_chk("R8 pending of both", 3'd5, 32'h600);
    wr(3'd5, 32'h600);
    wr(3'd1, '0); wr(3'd2, '0);
    ext[9] = 1'b0; ext[10] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sw;
    wr(3'd4, 32'h80);
    rd_chk("R9 trigger bit set", 3'd4, 32'h80);
    rd_chk("R9 pending set", 3'd5, 32'h80);
    wr(3'd4, 32'h0);
    rd_chk("R9 zero write no effect", 3'd4, 32'h80);
    wr(3'd5, 32'h80);
    rd_chk("R9 trigger auto clear", 3'd4, 32'h0);
    rd_chk("R9 pending cleared", 3'd5, 32'h0);
  endtask

  task automatic t_addr;
    wr(3'd0, 32'h000A_AAA5);
    wr(3'd1, 32'h0005_0003);
    wr(3'd3, 32'h0000_0C00);
    wr(3'd6, '1);
    wr(3'd7, '1);
    rd_chk("R10 index 6 reads zero", 3'd6, 32'h0);
    rd_chk("R10 index 7 reads zero", 3'd7, 32'h0);
    rd_chk("R10 ien kept", 3'd0, 32'h000A_AAA5);
    rd_chk("R10 een kept", 3'd1, 32'h0005_0003);
    rd_chk("R10 fall kept", 3'd3, 32'h0000_0C00);
    rd_chk("R10 pend kept", 3'd5, 32'h0);
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd3, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unimpl();
    t_rise();
    t_fall_both();
    t_w1c();
    t_priority();
    t_irq();
    t_event();
    t_sw();
    t_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule